// File: doc/BRIEF.md
# Single-Wire Bus Target Bit Engine

This block is the target end of a half-duplex serial link carried on a single open-drain data line that idles high. The host begins every bit slot by pulling the line low. The block times each low pulse against a one-microsecond tick. A short pulse is a bit slot. A pulse in the middle range cancels the byte in progress. A very long pulse is a bus reset, and the block answers it with its own presence pulse once the host lets go of the line.

In a write slot the block samples the line a fixed time after the falling edge and shifts the bit into a byte, least significant bit first. After the eighth slot it presents the byte with a one-cycle strobe. In a read slot it sends one bit of a byte supplied by the controller. For a 0 it holds the line low past the host strobe, and for a 1 it leaves the line released. The direction of a byte comes from a select input, which is sampled when the first slot of the byte begins. A higher-level controller decodes commands and holds any storage.

The line input passes through a two-flop synchroniser. The single output `pull_low` enables an external open-drain pull-down. The host may leave the line idle for any length of time between slots, and the byte then continues from the same position.

Top module: `swb_target`

## Requirements
- R1: After synchronous reset `pull_low`, `rx_valid`, `tx_done` and `reset_seen` are all 0.
- R2: In a write slot the bit is the line level 30 µs after the falling edge. A line still low at that point gives 0. A line already released gives 1 (low for 25 µs gives 1, low for 35 µs gives 0).
- R3: Write bits fill the byte least significant bit first. When the eighth write slot ends, `rx_valid` is high for exactly one clock cycle and `rx_byte` holds the assembled byte.
- R4: In a read slot whose bit is 0, `pull_low` is high from just after the falling edge until 45 µs after it. A 1 bit never asserts `pull_low`. Bits go out least significant bit first from `tx_byte`, which is captured when the first slot of the byte starts. `tx_done` pulses for one cycle after the eighth read slot.
- R5: A low pulse of 480 µs or more is a bus reset. When the line is released, `reset_seen` pulses for one cycle and any partial byte is discarded. `reset_seen` never coincides with `rx_valid` or `tx_done`.
- R6: After a bus reset, `pull_low` stays 0 for 30 µs after the release and is then high for 120 µs.
- R7: With the default setting, a low pulse of at least 120 µs but under 480 µs discards the partial byte. It gives no presence pulse and no `reset_seen`. A parameter can make such pulses act as full resets.
- R8: The line may stay idle high for any time between slots. The following slot continues the same byte.
- R9: `send_mode` (1 = read slots, 0 = write slots) is sampled only at the start of the first slot of a byte. Changing it later in the byte has no effect.
- R10: `pull_low` is never high for more than 120 µs without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| line_in | input | 1 | Level of the open-drain data line (asynchronous) |
| send_mode | input | 1 | Byte direction: 1 = target sends, 0 = target receives |
| tx_byte | input | 8 | Byte to send, captured at the first slot of a read byte |
| pull_low | output | 1 | Enable for the external pull-down on the data line |
| rx_byte | output | 8 | Last byte assembled by the shifter |
| rx_valid | output | 1 | One-cycle strobe marking a received byte |
| tx_done | output | 1 | One-cycle strobe marking a fully sent byte |
| reset_seen | output | 1 | One-cycle strobe when a bus reset is released |

## Verification
The assertions assume that `us_tick` is a single-cycle pulse with many clocks between pulses. They also assume that the host changes the line far more slowly than the clock, so every low pulse lasts many tick periods. The stimulus keeps each host low time at least 5 µs away from the 30, 45, 120 and 480 µs decision points. Write-0 slots last 60 µs, write-1 slots 5 µs, read strobes 2 µs, short resets 200 µs and long resets 500 µs. The host samples read data and presence at instants more than 5 µs from any edge the block may place.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SLOT     = 2'd1,
        ST_PRES_GAP = 2'd2,
        ST_PRES_LOW = 2'd3
    } swb_state_e;

    typedef enum logic [1:0] {
        LOW_BIT   = 2'd0,
        LOW_SHORT = 2'd1,
        LOW_LONG  = 2'd2
    } low_kind_e;

    // Sort a finished low pulse by its length in microseconds.
    function automatic low_kind_e classify_low(input int len_us,
                                               input int short_us,
                                               input int long_us);
        if (len_us >= long_us)
            return LOW_LONG;
        else if (len_us >= short_us)
            return LOW_SHORT;
        return LOW_BIT;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swb_line_sync.sv
module swb_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fell,
    output logic rose
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign line_s = s2;
    assign fell   = s3 & ~s2;
    assign rose   = ~s3 & s2;
endmodule

// File: rtl/swb_us_timer.sv
module swb_us_timer #(
    parameter int CW    = 9,
    parameter int LIMIT = 480
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    // Saturating count of microseconds since the last clear.
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (tick && (count != TOP))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/swb_bit_shifter.sv
module swb_bit_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            commit,
    input  logic            commit_bit,
    input  logic            abort,
    output logic            tx_bit,
    output logic            first_slot,
    output logic            done,
    output logic [BITS-1:0] word
);
    localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [BCW-1:0] LAST = BCW'(BITS - 1);

    logic [BCW-1:0]  idx;
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;
    logic [BITS-1:0] rx_next;

    assign rx_next = {commit_bit, rx_sh[BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            word  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load)
                tx_sh <= load_val;
            if (abort) begin
                idx <= '0;
            end else if (commit) begin
                tx_sh <= {1'b0, tx_sh[BITS-1:1]};
                rx_sh <= rx_next;
                if (idx == LAST) begin
                    idx  <= '0;
                    done <= 1'b1;
                    word <= rx_next;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign tx_bit     = tx_sh[0];
    assign first_slot = (idx == '0);
endmodule

// File: rtl/swb_target.sv
module swb_target
    import swb_pkg::*;
#(
    parameter int BITS           = 8,
    parameter int SAMPLE_US      = 30,
    parameter int READ_HOLD_US   = 45,
    parameter int SHORT_RST_US   = 120,
    parameter int LONG_RST_US    = 480,
    parameter int PRES_GAP_US    = 30,
    parameter int PRES_LEN_US    = 120,
    parameter bit SHORT_IS_RESET = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            us_tick,
    input  logic            line_in,
    input  logic            send_mode,
    input  logic [BITS-1:0] tx_byte,
    output logic            pull_low,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_valid,
    output logic            tx_done,
    output logic            reset_seen
);
    localparam int MAXC = max2(max2(LONG_RST_US, PRES_LEN_US),
                               max2(READ_HOLD_US, PRES_GAP_US));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] C_SAMPLE = CW'(SAMPLE_US);
    localparam logic [CW-1:0] C_HOLD   = CW'(READ_HOLD_US);
    localparam logic [CW-1:0] C_GAP    = CW'(PRES_GAP_US);
    localparam logic [CW-1:0] C_PRES   = CW'(PRES_LEN_US);

    swb_state_e    state;
    logic          line_s, fell, rose;
    logic          clr;
    logic [CW-1:0] cnt;
    logic          dir_q;
    logic          samp;
    logic          tx_bit, first_slot, done;
    low_kind_e     kind;
    logic          slot_start, slot_end;
    logic          bit_end, reset_end, abort_end;

    swb_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_in(line_in),
        .line_s (line_s),
        .fell   (fell),
        .rose   (rose)
    );

    swb_us_timer #(.CW(CW), .LIMIT(MAXC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick),
        .clr  (clr),
        .count(cnt)
    );

    assign kind       = classify_low(int'(cnt), SHORT_RST_US, LONG_RST_US);
    assign slot_start = (state == ST_IDLE) && fell;
    assign slot_end   = (state == ST_SLOT) && rose;
    assign bit_end    = slot_end && (kind == LOW_BIT);
    assign reset_end  = slot_end && ((kind == LOW_LONG) ||
                                     ((kind == LOW_SHORT) && SHORT_IS_RESET));
    assign abort_end  = slot_end && (kind == LOW_SHORT) && !SHORT_IS_RESET;

    // The timer restarts at every slot edge and at each presence phase.
    assign clr = slot_start || reset_end ||
                 ((state == ST_PRES_GAP) && (cnt == C_GAP));

    swb_bit_shifter #(.BITS(BITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (slot_start && first_slot),
        .load_val  (tx_byte),
        .commit    (bit_end),
        .commit_bit(samp),
        .abort     (reset_end || abort_end),
        .tx_bit    (tx_bit),
        .first_slot(first_slot),
        .done      (done),
        .word      (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dir_q      <= 1'b0;
            samp       <= 1'b1;
            reset_seen <= 1'b0;
        end else begin
            reset_seen <= reset_end;
            unique case (state)
                ST_IDLE: begin
                    if (fell) begin
                        state <= ST_SLOT;
                        samp  <= 1'b1;
                        if (first_slot)
                            dir_q <= send_mode;
                    end
                end
                ST_SLOT: begin
                    if (cnt == C_SAMPLE)
                        samp <= line_s;
                    if (rose)
                        state <= reset_end ? ST_PRES_GAP : ST_IDLE;
                end
                ST_PRES_GAP: begin
                    if (cnt == C_GAP)
                        state <= ST_PRES_LOW;
                end
                ST_PRES_LOW: begin
                    if (cnt == C_PRES)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pull_low = ((state == ST_SLOT) && dir_q && !tx_bit && (cnt < C_HOLD)) ||
                      (state == ST_PRES_LOW);
    assign rx_valid = done && !dir_q;
    assign tx_done  = done && dir_q;
endmodule

// File: rtl/swb_target_chk.sv
module swb_target_chk #(
    parameter int PRES_LEN_US = 120
) (
    input logic clk,
    input logic rst,
    input logic us_tick,
    input logic pull_low,
    input logic rx_valid,
    input logic tx_done,
    input logic reset_seen
);
    localparam int RW = $clog2(PRES_LEN_US + 2) + 1;
    localparam logic [RW-1:0] RUN_MAX = RW'(PRES_LEN_US);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !pull_low)
            low_run <= '0;
        else if (us_tick && (low_run <= RUN_MAX))
            low_run <= low_run + 1'b1;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!pull_low && !rx_valid && !tx_done && !reset_seen));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_single_done_r4: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    p_no_byte_on_reset_r5: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> (!rx_valid && !tx_done));

    p_gap_before_presence_r6: assert property (@(posedge clk) disable iff (rst)
        reset_seen |=> !pull_low);

    p_drive_limit_r10: assert property (@(posedge clk) disable iff (rst)
        low_run <= RUN_MAX);
endmodule

bind swb_target swb_target_chk #(.PRES_LEN_US(PRES_LEN_US)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .us_tick   (us_tick),
    .pull_low  (pull_low),
    .rx_valid  (rx_valid),
    .tx_done   (tx_done),
    .reset_seen(reset_seen)
);

// File: tb/sim_swb_target.sv
module sim_swb_target;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       host_low = 1'b0;
    logic       send_mode = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       pull_low, rx_valid, tx_done, reset_seen;
    logic [7:0] rx_byte;
    wire        line_in = ~(host_low | pull_low);

    int checks = 0, bad = 0;
    int rx_cnt = 0, txd_cnt = 0, rs_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    int div = 0, cyc = 0;

    swb_target u0 (
        .clk       (clk),
        .rst       (rst),
        .us_tick   (us_tick),
        .line_in   (line_in),
        .send_mode (send_mode),
        .tx_byte   (tx_byte),
        .pull_low  (pull_low),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .tx_done   (tx_done),
        .reset_seen(reset_seen)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div <= (div == 9) ? 0 : div + 1;
        us_tick <= (div == 9);
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
            if (tx_done) txd_cnt++;
            if (reset_seen) rs_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            bad++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * 10) @(negedge clk);
    endtask

    task automatic slot_low(input int low_us);
        host_low = 1'b1;
        wait_us(low_us);
        host_low = 1'b0;
        wait_us(70 - low_us);
    endtask

    task automatic wr_bit(input bit b);
        slot_low(b ? 5 : 60);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) wr_bit(d[i]);
    endtask

    task automatic rd_bit(output bit b);
        host_low = 1'b1;
        wait_us(2);
        host_low = 1'b0;
        wait_us(13);
        b = line_in;
        wait_us(55);
    endtask

    task automatic rd_byte(output logic [7:0] d);
        bit b;
        for (int i = 0; i < 8; i++) begin rd_bit(b); d[i] = b; end
    endtask

    // kind bit 8: 1 = read byte, 0 = write byte
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
        {1'b1, 8'hFF}, {1'b0, 8'h80}, {1'b1, 8'h01}
    };

    initial begin
        logic [7:0] got;
        bit b;
        int n0, t0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wait_us(5);
        // R1 reset state
        check(pull_low == 1'b0, "R1 pull_low", pull_low, 0);
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        check(tx_done == 1'b0, "R1 tx_done", tx_done, 0);
        check(reset_seen == 1'b0, "R1 reset_seen", reset_seen, 0);

        // table walk: R2 R3 (write) and R4 (read)
        for (int v = 0; v < 6; v++) begin
            n0 = rx_cnt; t0 = txd_cnt;
            if (VEC[v][8]) begin
                send_mode = 1'b1; tx_byte = VEC[v][7:0];
                rd_byte(got);
                check(got == VEC[v][7:0], "R4 read byte", got, VEC[v][7:0]);
                check(txd_cnt == t0 + 1 && rx_cnt == n0, "R4 tx_done count", txd_cnt - t0, 1);
            end else begin
                send_mode = 1'b0;
                wr_byte(VEC[v][7:0]);
                check(rx_cnt == n0 + 1, "R3 rx_valid count", rx_cnt - n0, 1);
                check(rx_last == VEC[v][7:0], "R3 rx byte", rx_last, VEC[v][7:0]);
            end
        end

        // R2 sample point: 25 us low gives 1, 35 us low gives 0
        send_mode = 1'b0; n0 = rx_cnt;
        for (int i = 0; i < 8; i++) slot_low((i % 2 == 0) ? 25 : 35);
        check(rx_cnt == n0 + 1 && rx_last == 8'h55, "R2 sample boundary", rx_last, 8'h55);

        // R4 drive window of a read-0 bit
        send_mode = 1'b1; tx_byte = 8'hFE; t0 = txd_cnt;
        host_low = 1'b1; wait_us(2); host_low = 1'b0;
        wait_us(38);
        check(pull_low == 1'b1, "R4 held at 40us", pull_low, 1);
        wait_us(10);
        check(pull_low == 1'b0, "R4 released by 50us", pull_low, 0);
        wait_us(20);
        got = 8'h00;
        for (int i = 1; i < 8; i++) begin rd_bit(b); got[i] = b; end
        check(got == 8'hFE && txd_cnt == t0 + 1, "R4 remaining bits", got, 8'hFE);

        // R9 direction sampled only at first slot
        send_mode = 1'b0; n0 = rx_cnt; t0 = txd_cnt;
        wr_bit(1'b1);
        send_mode = 1'b1; tx_byte = 8'h00;
        for (int i = 1; i < 8; i++) wr_bit(i[0]);
        check(rx_cnt == n0 + 1 && rx_last == 8'hAB && txd_cnt == t0,
              "R9 direction hold", rx_last, 8'hAB);

        // R5 R6 R10 long reset and presence pulse
        send_mode = 1'b0;
        wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
        r0 = rs_cnt;
        host_low = 1'b1; wait_us(500); host_low = 1'b0;
        wait_us(20);
        check(pull_low == 1'b0, "R6 gap before presence", pull_low, 0);
        check(rs_cnt == r0 + 1, "R5 reset_seen pulse", rs_cnt - r0, 1);
        wait_us(20);
        check(pull_low == 1'b1, "R6 presence at 40us", pull_low, 1);
        wait_us(100);
        check(pull_low == 1'b1, "R6 presence at 140us", pull_low, 1);
        wait_us(20);
        check(pull_low == 1'b0, "R10 presence ended at 160us", pull_low, 0);
        n0 = rx_cnt;
        wr_byte(8'h5A);
        check(rx_cnt == n0 + 1 && rx_last == 8'h5A, "R5 partial byte discarded", rx_last, 8'h5A);

        // R7 short low aborts without presence
        wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b1);
        r0 = rs_cnt;
        host_low = 1'b1; wait_us(200); host_low = 1'b0;
        wait_us(40);
        check(pull_low == 1'b0, "R7 no presence at 40us", pull_low, 0);
        wait_us(60);
        check(pull_low == 1'b0, "R7 no presence at 100us", pull_low, 0);
        check(rs_cnt == r0, "R7 no reset_seen", rs_cnt - r0, 0);
        n0 = rx_cnt;
        wr_byte(8'hC3);
        check(rx_cnt == n0 + 1 && rx_last == 8'hC3, "R7 byte restarted", rx_last, 8'hC3);

        // R8 idle pause inside a byte
        n0 = rx_cnt;
        for (int i = 0; i < 4; i++) wr_bit(i == 1 || i == 2);
        wait_us(1000);
        check(rx_cnt == n0, "R8 no byte during pause", rx_cnt - n0, 0);
        for (int i = 4; i < 8; i++) wr_bit(i == 4 || i == 7);
        check(rx_cnt == n0 + 1 && rx_last == 8'h96, "R8 byte after pause", rx_last, 8'h96);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule